// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block takes one secondary processor core from fully unpowered to running. A start request carries a core index. For any index other than zero, the block goes through a fixed ramp. It first enables the core's head switch with its LDO held powered down. It then turns on all head-switch segments and hands supply to the head switch by setting every LDO bypass bit. Halfway through, it writes the shared L2 regulator word once. Last, it walks the core control bits from reset with clamp, to reset only, to released, and finally to powered-up.

Each step holds its outputs for a settle time. That time is a fixed number of units, and each unit is a parameterised number of clock cycles. A request for core 0 is never sequenced, because doing so would power down the running core. Such a request completes at once with success and leaves every output unchanged. All outputs are registered. After completion they keep their final values until a reset or a new accepted request.

Top module: `core_pwrup_seq`

## Requirements
- R1: A synchronous reset, asserted at any time, forces busy, done, ok and the L2 strobe to 0, the power-gate word to 0, the L2 word to 0, and the core control vector to 3'b011 (bit 0 reset, bit 1 clamp, bit 2 powered-up).
- R2: A request accepted with core index 0 raises done and ok for exactly one cycle on the next edge. Busy stays low, and the power-gate word, the core control vector and the L2 word keep their values.
- R3: One edge after a request for a nonzero core is accepted, busy rises and the control vector becomes 3'b011. The gate word then holds, for HS_UNITS*UNIT_CYC cycles, the enable bit 0, the count value 64 in bits 8:1 and all ones in the power-down mask bits 15:10, with bits 21:16 and 29:24 clear (0x0000FC81).
- R4: The next step keeps those bits, adds all six segment bits 21:16 (0x003FFC81) and holds for HS_UNITS*UNIT_CYC cycles.
- R5: The third step adds all six bypass bits 29:24 (0x3F3FFC81). On the same edge the L2 word becomes 0x00010003 and the L2 strobe is high for one cycle. This step holds for L2_UNITS*UNIT_CYC cycles.
- R6: The control vector then shows 3'b011 for RST_UNITS*UNIT_CYC cycles, then 3'b001 for RST_UNITS*UNIT_CYC cycles, then 3'b000 for one cycle. The clamp is never dropped without reset, and reset is never dropped with the clamp on.
- R7: On the next edge the control vector becomes 3'b100 and done and ok pulse for one cycle. Busy falls on that edge, so it is high from the edge after acceptance through the cycle before done.
- R8: A start request, with any index, that arrives while busy is high is ignored and does not change the sequence or its timing.
- R9: After completion, the gate word, control vector and L2 word keep their final values while idle.
- R10: A new nonzero request after a completed sequence restarts the ramp from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, taken when idle |
| core_idx_i | input | IDX_W | Index of the core to bring up |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success flag, pulses with done |
| pg_word_o | output | WORD_W | Power-gate control word |
| core_ctl_o | output | 3 | Core control: bit 0 reset, bit 1 clamp, bit 2 powered-up |
| l2_word_o | output | WORD_W | Shared L2 regulator control word |
| l2_wr_o | output | 1 | One-cycle write strobe for the L2 word |

## Verification
The bench runs clean sequences, and these show the ordering and the exact dwell of every step against a cycle-indexed model. It also runs sequences with random start pulses during busy, using random indices that include zero. These show that a request taken mid-ramp would disturb the timing or restart the ramp. Core-0 requests are issued from the reset state and from the fully powered state, which tells a true no-op apart from a reload of idle values. A reset in the middle of the ramp, followed by back-to-back runs, separates return-to-idle from a restart that carries stale words.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_SEGS,
    ST_BYPASS,
    ST_HOLD,
    ST_UNCLAMP,
    ST_RELEASE
  } seq_state_t;

  // control vector bit positions
  localparam int CTL_RST   = 0;
  localparam int CTL_CLAMP = 1;
  localparam int CTL_UP    = 2;

  function automatic int unsigned dwell_cycles(int unsigned units, int unsigned unit_cyc);
    return units * unit_cyc;
  endfunction

  function automatic logic [2:0] mk_ctl(logic rst_b, logic clamp_b, logic up_b);
    logic [2:0] v;
    v = '0;
    v[CTL_RST]   = rst_b;
    v[CTL_CLAMP] = clamp_b;
    v[CTL_UP]    = up_b;
    return v;
  endfunction

endpackage

// File: rtl/pwrup_settle_timer.sv
module pwrup_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                    count_q <= '0;
    else if (load_i)            count_q <= load_val_i;
    else if (count_q != '0)     count_q <= count_q - CNT_W'(1);
  end

  // high in the last cycle of a dwell, so the step changes after exactly load_val cycles
  assign expire_o = (count_q == CNT_W'(1));

endmodule

// File: rtl/pwrup_gate_word.sv
module pwrup_gate_word #(
  parameter int WORD_W    = 32,
  parameter int HS_EN_BIT = 0,
  parameter int CNT_LSB   = 1,
  parameter int CNT_FW    = 8,
  parameter int HS_COUNT  = 64,
  parameter int NSEG      = 6,
  parameter int PD_LSB    = 10,
  parameter int SEG_LSB   = 16,
  parameter int BYP_LSB   = 24
) (
  input  logic [1:0]        lvl_i,
  output logic [WORD_W-1:0] word_o
);

  function automatic logic [WORD_W-1:0] seg_mask(int lsb);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSEG; i++) m[lsb + i] = 1'b1;
    return m;
  endfunction

  always_comb begin
    word_o = '0;
    if (lvl_i != 2'd0) begin
      word_o[HS_EN_BIT]          = 1'b1;
      word_o[CNT_LSB +: CNT_FW]  = CNT_FW'(HS_COUNT);
      word_o                     = word_o | seg_mask(PD_LSB);
    end
    if (lvl_i >= 2'd2) word_o = word_o | seg_mask(SEG_LSB);
    if (lvl_i == 2'd3) word_o = word_o | seg_mask(BYP_LSB);
  end

endmodule

// File: rtl/pwrup_step_fsm.sv
module pwrup_step_fsm
  import pwrup_pkg::*;
#(
  parameter int              IDX_W  = 2,
  parameter int              WORD_W = 32,
  parameter int              CNT_W  = 8,
  parameter int              N_HS   = 3,
  parameter int              N_L2   = 150,
  parameter int              N_RST  = 6,
  parameter logic [WORD_W-1:0] L2_VAL = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  core_idx_i,
  input  logic              expire_i,
  input  logic [WORD_W-1:0] pg_word_nxt_i,
  output logic [1:0]        lvl_nxt_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              accept_o,
  output logic              skip_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [WORD_W-1:0] pg_word_o,
  output logic [2:0]        core_ctl_o,
  output logic [WORD_W-1:0] l2_word_o,
  output logic              l2_wr_o
);

  seq_state_t        state_q, state_n;
  logic [1:0]        lvl_q;
  logic [2:0]        ctl_n;
  logic [WORD_W-1:0] l2w_n;
  logic              l2wr_n, busy_n, done_n, ok_n;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign skip_o   = accept_o && (core_idx_i == '0);

  always_comb begin
    state_n    = state_q;
    lvl_nxt_o  = lvl_q;
    ctl_n      = core_ctl_o;
    l2w_n      = l2_word_o;
    l2wr_n     = 1'b0;
    busy_n     = busy_o;
    done_n     = 1'b0;
    ok_n       = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (skip_o) begin
          done_n = 1'b1;
          ok_n   = 1'b1;
        end else if (accept_o) begin
          state_n    = ST_GATE;
          lvl_nxt_o  = 2'd1;
          ctl_n      = mk_ctl(1'b1, 1'b1, 1'b0);
          busy_n     = 1'b1;
          load_o     = 1'b1;
          load_val_o = CNT_W'(N_HS);
        end
      end
      ST_GATE: if (expire_i) begin
        state_n    = ST_SEGS;
        lvl_nxt_o  = 2'd2;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_HS);
      end
      ST_SEGS: if (expire_i) begin
        state_n    = ST_BYPASS;
        lvl_nxt_o  = 2'd3;
        l2w_n      = L2_VAL;
        l2wr_n     = 1'b1;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_L2);
      end
      ST_BYPASS: if (expire_i) begin
        state_n    = ST_HOLD;
        ctl_n      = mk_ctl(1'b1, 1'b1, 1'b0);
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_RST);
      end
      ST_HOLD: if (expire_i) begin
        state_n    = ST_UNCLAMP;
        ctl_n      = mk_ctl(1'b1, 1'b0, 1'b0);
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_RST);
      end
      ST_UNCLAMP: if (expire_i) begin
        state_n = ST_RELEASE;
        ctl_n   = mk_ctl(1'b0, 1'b0, 1'b0);
      end
      ST_RELEASE: begin
        state_n = ST_IDLE;
        ctl_n   = mk_ctl(1'b0, 1'b0, 1'b1);
        busy_n  = 1'b0;
        done_n  = 1'b1;
        ok_n    = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lvl_q      <= 2'd0;
      pg_word_o  <= '0;
      core_ctl_o <= mk_ctl(1'b1, 1'b1, 1'b0);
      l2_word_o  <= '0;
      l2_wr_o    <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
    end else begin
      state_q    <= state_n;
      lvl_q      <= lvl_nxt_o;
      pg_word_o  <= pg_word_nxt_i;
      core_ctl_o <= ctl_n;
      l2_word_o  <= l2w_n;
      l2_wr_o    <= l2wr_n;
      busy_o     <= busy_n;
      done_o     <= done_n;
      ok_o       <= ok_n;
    end
  end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq #(
  parameter int              WORD_W    = 32,
  parameter int              IDX_W     = 2,
  parameter int              UNIT_CYC  = 3,
  parameter int              HS_UNITS  = 1,
  parameter int              L2_UNITS  = 50,
  parameter int              RST_UNITS = 2,
  parameter int              HS_EN_BIT = 0,
  parameter int              CNT_LSB   = 1,
  parameter int              CNT_FW    = 8,
  parameter int              HS_COUNT  = 64,
  parameter int              NSEG      = 6,
  parameter int              PD_LSB    = 10,
  parameter int              SEG_LSB   = 16,
  parameter int              BYP_LSB   = 24,
  parameter logic [WORD_W-1:0] L2_VAL  = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  core_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [WORD_W-1:0] pg_word_o,
  output logic [2:0]        core_ctl_o,
  output logic [WORD_W-1:0] l2_word_o,
  output logic              l2_wr_o
);

  localparam int N_HS  = pwrup_pkg::dwell_cycles(HS_UNITS, UNIT_CYC);
  localparam int N_L2  = pwrup_pkg::dwell_cycles(L2_UNITS, UNIT_CYC);
  localparam int N_RST = pwrup_pkg::dwell_cycles(RST_UNITS, UNIT_CYC);
  localparam int N_MAX = (N_L2 > N_HS) ? ((N_L2 > N_RST) ? N_L2 : N_RST)
                                       : ((N_HS > N_RST) ? N_HS : N_RST);
  localparam int CNT_W = $clog2(N_MAX + 1);

  // named internal events, visible to the bound checker
  logic              accept_w;
  logic              skip_w;
  logic              expire_w;
  logic              load_w;
  logic [CNT_W-1:0]  load_val_w;
  logic [1:0]        lvl_nxt_w;
  logic [WORD_W-1:0] pg_word_nxt_w;

  pwrup_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .expire_o   (expire_w)
  );

  pwrup_gate_word #(
    .WORD_W   (WORD_W),
    .HS_EN_BIT(HS_EN_BIT),
    .CNT_LSB  (CNT_LSB),
    .CNT_FW   (CNT_FW),
    .HS_COUNT (HS_COUNT),
    .NSEG     (NSEG),
    .PD_LSB   (PD_LSB),
    .SEG_LSB  (SEG_LSB),
    .BYP_LSB  (BYP_LSB)
  ) u_word (
    .lvl_i  (lvl_nxt_w),
    .word_o (pg_word_nxt_w)
  );

  pwrup_step_fsm #(
    .IDX_W (IDX_W),
    .WORD_W(WORD_W),
    .CNT_W (CNT_W),
    .N_HS  (N_HS),
    .N_L2  (N_L2),
    .N_RST (N_RST),
    .L2_VAL(L2_VAL)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .core_idx_i   (core_idx_i),
    .expire_i     (expire_w),
    .pg_word_nxt_i(pg_word_nxt_w),
    .lvl_nxt_o    (lvl_nxt_w),
    .load_o       (load_w),
    .load_val_o   (load_val_w),
    .accept_o     (accept_w),
    .skip_o       (skip_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ok_o         (ok_o),
    .pg_word_o    (pg_word_o),
    .core_ctl_o   (core_ctl_o),
    .l2_word_o    (l2_word_o),
    .l2_wr_o      (l2_wr_o)
  );

endmodule

// File: rtl/pwrup_seq_checker.sv
module pwrup_seq_checker #(
  parameter int              WORD_W = 32,
  parameter logic [WORD_W-1:0] L2_VAL = 32'h0001_0003
) (
  input logic              clk,
  input logic              rst,
  input logic              skip_w,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic [WORD_W-1:0] pg_word_o,
  input logic [2:0]        core_ctl_o,
  input logic [WORD_W-1:0] l2_word_o,
  input logic              l2_wr_o
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!busy_o && !done_o && !ok_o && !l2_wr_o && pg_word_o == '0
               && l2_word_o == '0 && core_ctl_o == 3'b011));

  assert_core0_noop_R2: assert property (@(posedge clk) disable iff (rst)
    skip_w |=> (done_o && ok_o && !busy_o && $stable(pg_word_o)
                && $stable(core_ctl_o) && $stable(l2_word_o)));

  assert_ramp_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ((pg_word_o & $past(pg_word_o)) == $past(pg_word_o)));

  assert_l2_value_R5: assert property (@(posedge clk) disable iff (rst)
    l2_wr_o |-> (l2_word_o == L2_VAL && busy_o));

  assert_l2_single_R5: assert property (@(posedge clk) disable iff (rst)
    l2_wr_o |=> !l2_wr_o);

  assert_unclamp_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_ctl_o[1]) |-> core_ctl_o[0]);

  assert_release_unclamped_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_ctl_o[0]) |-> !core_ctl_o[1]);

  assert_pwrup_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_ctl_o[2]) |-> (done_o && ok_o));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_ends_in_done_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !rst_q) |-> done_o);

endmodule

bind core_pwrup_seq pwrup_seq_checker #(.WORD_W(WORD_W), .L2_VAL(L2_VAL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .skip_w    (skip_w),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ok_o      (ok_o),
  .pg_word_o (pg_word_o),
  .core_ctl_o(core_ctl_o),
  .l2_word_o (l2_word_o),
  .l2_wr_o   (l2_wr_o)
);

// File: tb/test_core_pwrup_seq.sv
module test_core_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int A  = 3;    // head-switch step dwell: 1 unit * 3 cycles
  localparam int B  = 150;  // regulator settle: 50 units * 3 cycles
  localparam int C  = 6;    // reset/clamp dwell: 2 units * 3 cycles
  localparam int TD = 2*A + B + 2*C + 1;
  localparam logic [31:0] L2V = 32'h0001_0003;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [1:0]  core_idx_i;
  logic        busy_o, done_o, ok_o, l2_wr_o;
  logic [31:0] pg_word_o, l2_word_o;
  logic [2:0]  core_ctl_o;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] prev_pg;
  logic [2:0]  prev_ctl;
  logic [31:0] prev_l2;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwrup_seq i_core_pwrup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .core_idx_i(core_idx_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .pg_word_o(pg_word_o),
    .core_ctl_o(core_ctl_o), .l2_word_o(l2_word_o), .l2_wr_o(l2_wr_o)
  );

  // gate word by ramp stage, written as sums of field values
  function automatic logic [31:0] gate_word(int stage);
    logic [31:0] w;
    w = 0;
    if (stage >= 1) w = w + 32'd1 + 32'd64 * 32'd2 + 32'd63 * 32'd1024;
    if (stage >= 2) w = w + 32'd63 * 32'd65536;
    if (stage >= 3) w = w + 32'd63 * 32'd16777216;
    return w;
  endfunction

  function automatic int stage_at(int t);
    if (t < A)   return 1;
    if (t < 2*A) return 2;
    return 3;
  endfunction

  function automatic logic [2:0] ctl_at(int t);
    if (t < 2*A + B + C)   return 3'b011;
    if (t < 2*A + B + 2*C) return 3'b001;
    if (t < TD)            return 3'b000;
    return 3'b100;
  endfunction

  function automatic string tag_at(int t);
    if (t < A)     return "R3";
    if (t < 2*A)   return "R4";
    if (t < 2*A+B) return "R5";
    if (t < TD)    return "R6";
    if (t == TD)   return "R7";
    return "R9";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic bz, logic dn, logic [31:0] pg,
                         logic [2:0] ctl, logic [31:0] l2, logic wr);
    chk(req, "busy",  {31'd0, busy_o},  {31'd0, bz});
    chk(req, "done",  {31'd0, done_o},  {31'd0, dn});
    chk(req, "ok",    {31'd0, ok_o},    {31'd0, dn});
    chk(req, "pg",    pg_word_o,        pg);
    chk(req, "ctl",   {29'd0, core_ctl_o}, {29'd0, ctl});
    chk(req, "l2",    l2_word_o,        l2);
    chk(req, "l2wr",  {31'd0, l2_wr_o}, {31'd0, wr});
  endtask

  task automatic check_reset_vals();
    chk_all("R1", 1'b0, 1'b0, 32'd0, 3'b011, 32'd0, 1'b0);
    prev_pg = 32'd0; prev_ctl = 3'b011; prev_l2 = 32'd0;
  endtask

  task automatic run_req(logic [1:0] idx, bit garbage);
    string tg;
    @(negedge clk);
    start_i = 1'b1; core_idx_i = idx;
    @(negedge clk);
    start_i = 1'b0;
    if (idx == 2'd0) begin
      chk_all("R2", 1'b0, 1'b1, prev_pg, prev_ctl, prev_l2, 1'b0);
      @(negedge clk);
      chk_all("R2", 1'b0, 1'b0, prev_pg, prev_ctl, prev_l2, 1'b0);
      return;
    end
    for (int t = 0; t <= TD + 2; t++) begin
      tg = garbage ? {"R8/", tag_at(t)} : tag_at(t);
      if (t == 0) tg = {tg, "/R10"};
      chk_all(tg, t < TD, t == TD, gate_word(stage_at(t)), ctl_at(t),
              (t >= 2*A) ? L2V : prev_l2, t == 2*A);
      if (garbage && t < TD && ($urandom % 4) == 0) begin
        start_i = 1'b1; core_idx_i = 2'($urandom % 4);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    prev_pg = gate_word(3); prev_ctl = 3'b100; prev_l2 = L2V;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start_i = 1'b0; core_idx_i = 2'd0;
    repeat (3) @(negedge clk);
    check_reset_vals();                 // R1 at power-on
    rst = 1'b0;

    run_req(2'd0, 1'b0);                // R2 from reset state
    run_req(2'd1, 1'b0);                // clean ramp R3..R7
    repeat (5) begin                    // R9 idle hold
      @(negedge clk);
      chk_all("R9", 1'b0, 1'b0, prev_pg, prev_ctl, prev_l2, 1'b0);
    end
    run_req(2'd0, 1'b0);                // R2 from powered state
    run_req(2'd2, 1'b1);                // R8 and R10 restart
    run_req(2'd3, 1'b1);

    // R1: reset in the middle of a ramp
    @(negedge clk);
    start_i = 1'b1; core_idx_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_vals();
    rst = 1'b0;

    for (int k = 0; k < 4; k++) run_req(2'($urandom % 4), 1'b1);
    run_req(2'd0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule